// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after reset. It reads a few 16-bit words from a small three-wire serial EEPROM and uses them to configure a downstream-port hub. The EEPROM pins are shared with the status LED outputs of ports 1 and 2. The block checks the image against an additive checksum, then checks the port count and the power value against their legal ranges. If every check passes, it presents the stored vendor and product identifiers, the number of enabled ports, the per-port non-removable flags, the maximum power value and the three string lengths. If any check fails, it presents built-in defaults instead.

Byte `2n` of the image is the low half of EEPROM word `n`, and byte `2n+1` is the high half. While the block is loading, it drives the serial clock, chip select and data-in lines. The green port-2 line is then undriven and carries data from the EEPROM. When loading ends, the block raises a one-cycle done pulse and hands the pins back to the LED driver. If the image was accepted, the two amber LED lines stay low from then on, so that the EEPROM never sees a stray write.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: The vendor ID is word 0 (byte 0 low, byte 1 high) and the product ID is word 1 (byte 2 low, byte 3 high). The checksum is the low byte of word 2 (byte 4).
- R2: Each read holds `pin_cs` high and shifts the 9 bits `1,1,0,A5..A0` out on `pin_di`, MSB first. Each bit is valid at a rising edge of `pin_sk`. One dummy bit and 16 data bits follow, MSB first, and are sampled at the following rising edges. Each `pin_sk` half period is CLK_DIV clocks.
- R3: The image is accepted only if byte 4 equals (byte0 + byte1 + byte2 + byte3 + 1) mod 256.
- R4: The checksum is checked right after words 0, 1 and 2 have been read. On a mismatch, no further word is read.
- R5: The port count is byte 6, the low byte of word 3. A value outside 1 to 4 rejects the image.
- R6: The maximum power is byte 8, the low byte of word 4, in 2 mA units. A value above 0xFA rejects the image, and 0xFA itself is accepted.
- R7: `nonremovable[3:0]` is the low nibble of byte 7, the high byte of word 3. Bit 0 belongs to port 1, and a 1 means the device is non-removable.
- R8: The vendor, product and serial string lengths are the low bytes of words 8, 32 and 56 (byte offsets 0x10, 0x40 and 0x70). All three lengths are 0 when the image is rejected.
- R9: On rejection, `cfg_valid` is 0 and the outputs show DEF_VID, DEF_PID, 4 ports, all ports removable and power 0x32.
- R10: While `pins_owned` is 1, `pin_g2_oe` is 0. After release, `pin_sk` follows `led_green[0]`, `pin_g2_out` follows `led_green[1]`, and `pin_g2_oe` is 1.
- R11: After release with an accepted image, `pin_cs` and `pin_di` stay 0. With a rejected image, they follow `led_amber[0]` and `led_amber[1]`.
- R12: `pins_owned` is 1 from reset until `done` pulses. `done` is high for exactly one cycle, and `pins_owned` falls in that same cycle. `cfg_valid` is 0 before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts a load |
| pin_do | input | 1 | Serial data from the EEPROM (green port-2 line) |
| led_green | input | 2 | Green LED requests for ports 1 and 2 |
| led_amber | input | 2 | Amber LED requests for ports 1 and 2 |
| pin_sk | output | 1 | Serial clock / green port-1 line |
| pin_cs | output | 1 | Chip select / amber port-1 line |
| pin_di | output | 1 | Serial data to the EEPROM / amber port-2 line |
| pin_g2_out | output | 1 | Output value of the green port-2 line |
| pin_g2_oe | output | 1 | Output enable of the green port-2 line |
| pins_owned | output | 1 | Loader holds the shared pins |
| done | output | 1 | One-cycle pulse when loading ends |
| cfg_valid | output | 1 | The EEPROM image was accepted |
| vid | output | 16 | Vendor ID |
| pid | output | 16 | Product ID |
| port_cnt | output | 3 | Number of enabled ports |
| nonremovable | output | 4 | Per-port non-removable flags |
| max_power | output | 8 | Maximum power in 2 mA units |
| len_vendor | output | 8 | Vendor string length |
| len_product | output | 8 | Product string length |
| len_serial | output | 8 | Serial number string length |

## Verification
The hardest case to reach is the early abort: the checksum fails after the third word, and the loader must stop reading at that point. The bench's EEPROM model logs the address of every well-formed read command, so a run with a corrupted checksum byte can check that exactly addresses 0, 1 and 2 were fetched. The range rejections are exercised on both sides of each limit (ports 0, 1 and 5; power 0xFA and 0xFB). Each rejection is then confirmed by driving LED patterns and watching the amber pins follow them.

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int          CLK_DIV   = 8,
  parameter logic [15:0] DEF_VID   = 16'h1234,
  parameter logic [15:0] DEF_PID   = 16'h5678,
  parameter logic [2:0]  DEF_PORTS = 3'd4,
  parameter logic [7:0]  DEF_POWER = 8'h32,
  parameter logic [7:0]  MAX_POWER = 8'hFA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_do,
  input  logic [1:0]  led_green,
  input  logic [1:0]  led_amber,
  output logic        pin_sk,
  output logic        pin_cs,
  output logic        pin_di,
  output logic        pin_g2_out,
  output logic        pin_g2_oe,
  output logic        pins_owned,
  output logic        done,
  output logic        cfg_valid,
  output logic [15:0] vid,
  output logic [15:0] pid,
  output logic [2:0]  port_cnt,
  output logic [3:0]  nonremovable,
  output logic [7:0]  max_power,
  output logic [7:0]  len_vendor,
  output logic [7:0]  len_product,
  output logic [7:0]  len_serial
);
  localparam int DW      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CMD_LEN = 9;
  localparam int LAST    = CMD_LEN + 16;

  typedef enum logic [2:0] {S_GAP, S_LOW, S_HIGH, S_FIN, S_END} st_t;
  st_t state;

  logic [DW-1:0] div_cnt;
  logic [4:0]    bit_cnt;
  logic [2:0]    widx;
  logic [15:0]   shreg, vid_raw, pid_raw;
  logic [7:0]    csum_raw, ports_raw, pwr_raw, lv_raw, lp_raw, ls_raw;
  logic [3:0]    rem_raw;
  logic          sk, cs;

  wire tick = (div_cnt == DW'(CLK_DIV - 1));

  logic [5:0] addr;
  always_comb
    case (widx)
      3'd5:    addr = 6'd8;
      3'd6:    addr = 6'd32;
      3'd7:    addr = 6'd56;
      default: addr = {3'b000, widx};
    endcase

  wire [8:0] cmd    = {3'b110, addr};
  wire [3:0] cidx   = 4'd8 - bit_cnt[3:0];
  wire       di     = cs && (bit_cnt < 5'(CMD_LEN)) && cmd[cidx];
  wire [7:0] sum_p1 = vid_raw[7:0] + vid_raw[15:8] + pid_raw[7:0] + pid_raw[15:8] + 8'd1;
  wire       csum_ok  = (csum_raw == sum_p1);
  wire       accept   = csum_ok && (ports_raw >= 8'd1) && (ports_raw <= 8'd4) && (pwr_raw <= MAX_POWER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_GAP; div_cnt <= '0; bit_cnt <= '0; widx <= '0; shreg <= '0;
      sk <= 1'b0; cs <= 1'b0; pins_owned <= 1'b1; done <= 1'b0;
      vid_raw <= '0; pid_raw <= '0; csum_raw <= '0; ports_raw <= '0; rem_raw <= '0;
      pwr_raw <= '0; lv_raw <= '0; lp_raw <= '0; ls_raw <= '0;
      cfg_valid <= 1'b0; vid <= DEF_VID; pid <= DEF_PID; port_cnt <= DEF_PORTS;
      nonremovable <= '0; max_power <= DEF_POWER;
      len_vendor <= '0; len_product <= '0; len_serial <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_GAP:
          if (tick) begin
            div_cnt <= '0; cs <= 1'b1; bit_cnt <= '0; state <= S_LOW;
          end else div_cnt <= div_cnt + 1'b1;
        S_LOW:
          if (tick) begin
            div_cnt <= '0; sk <= 1'b1; state <= S_HIGH;
            if (bit_cnt > 5'(CMD_LEN)) shreg <= {shreg[14:0], pin_do};
          end else div_cnt <= div_cnt + 1'b1;
        S_HIGH:
          if (tick) begin
            div_cnt <= '0; sk <= 1'b0;
            if (bit_cnt == 5'(LAST)) begin
              cs <= 1'b0;
              case (widx)
                3'd0: vid_raw <= shreg;
                3'd1: pid_raw <= shreg;
                3'd2: csum_raw <= shreg[7:0];
                3'd3: begin ports_raw <= shreg[7:0]; rem_raw <= shreg[11:8]; end
                3'd4: pwr_raw <= shreg[7:0];
                3'd5: lv_raw <= shreg[7:0];
                3'd6: lp_raw <= shreg[7:0];
                default: ls_raw <= shreg[7:0];
              endcase
              if ((widx == 3'd2 && shreg[7:0] != sum_p1) || widx == 3'd7) state <= S_FIN;
              else begin widx <= widx + 1'b1; state <= S_GAP; end
            end else begin
              bit_cnt <= bit_cnt + 1'b1; state <= S_LOW;
            end
          end else div_cnt <= div_cnt + 1'b1;
        S_FIN: begin
          done <= 1'b1; pins_owned <= 1'b0; cfg_valid <= accept; state <= S_END;
          vid          <= accept ? vid_raw : DEF_VID;
          pid          <= accept ? pid_raw : DEF_PID;
          port_cnt     <= accept ? ports_raw[2:0] : DEF_PORTS;
          nonremovable <= accept ? rem_raw : 4'h0;
          max_power    <= accept ? pwr_raw : DEF_POWER;
          len_vendor   <= accept ? lv_raw : 8'h00;
          len_product  <= accept ? lp_raw : 8'h00;
          len_serial   <= accept ? ls_raw : 8'h00;
        end
        default: ;
      endcase
    end
  end

  assign pin_sk     = pins_owned ? sk : led_green[0];
  assign pin_cs     = pins_owned ? cs : (!cfg_valid && led_amber[0]);
  assign pin_di     = pins_owned ? di : (!cfg_valid && led_amber[1]);
  assign pin_g2_out = !pins_owned && led_green[1];
  assign pin_g2_oe  = !pins_owned;

  p_g2_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pins_owned |-> !pin_g2_oe);
  p_release_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins_owned) |-> done);
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_no_valid_early_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pins_owned |-> !cfg_valid);
  p_amber_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_owned && cfg_valid) |-> (!pin_cs && !pin_di));
  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (port_cnt >= 3'd1 && port_cnt <= 3'd4));
  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (max_power <= MAX_POWER));
  p_sk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_owned && !pin_cs) |-> !pin_sk);
endmodule

// File: tb/test_eeprom_cfg_loader.sv
`timescale 1ns/1ps
module test_eeprom_cfg_loader;
  localparam logic [15:0] DVID = 16'hABCD;
  localparam logic [15:0] DPID = 16'h4321;

  logic clk = 0, rst_n = 0, pin_do;
  logic [1:0] led_green = 0, led_amber = 0;
  logic pin_sk, pin_cs, pin_di, pin_g2_out, pin_g2_oe, pins_owned, done, cfg_valid;
  logic [15:0] vid, pid;
  logic [2:0] port_cnt;
  logic [3:0] nonremovable;
  logic [7:0] max_power, len_vendor, len_product, len_serial;

  int errors = 0, checks = 0, cycles = 0, proto_err = 0;

  eeprom_cfg_loader #(.CLK_DIV(2), .DEF_VID(DVID), .DEF_PID(DPID)) i_eeprom_cfg_loader (
    .clk(clk), .rst_n(rst_n), .pin_do(pin_do), .led_green(led_green), .led_amber(led_amber),
    .pin_sk(pin_sk), .pin_cs(pin_cs), .pin_di(pin_di), .pin_g2_out(pin_g2_out),
    .pin_g2_oe(pin_g2_oe), .pins_owned(pins_owned), .done(done), .cfg_valid(cfg_valid),
    .vid(vid), .pid(pid), .port_cnt(port_cnt), .nonremovable(nonremovable),
    .max_power(max_power), .len_vendor(len_vendor), .len_product(len_product),
    .len_serial(len_serial));

  always #2.5 clk = ~clk;

  // Behavioural EEPROM
  logic [15:0] mem [64];
  logic [8:0]  cmdsh;
  logic [15:0] cur;
  int bcnt = 0;
  int rd_q[$];
  logic m_do = 1'b1;
  assign pin_do = m_do;

  always @(posedge pin_sk) if (pins_owned && pin_cs) begin
    logic [8:0] nc;
    nc = {cmdsh[7:0], pin_di};
    if (bcnt < 9) cmdsh = nc;
    if (bcnt == 8) begin
      if (nc[8:6] == 3'b110) begin
        rd_q.push_back(int'(nc[5:0])); cur = mem[nc[5:0]]; m_do = 1'b0;
      end else begin
        proto_err++; cur = 16'hFFFF; m_do = 1'b1;
      end
    end else if (bcnt >= 9 && bcnt <= 24) m_do = cur[24 - bcnt];
    bcnt++;
  end
  always @(negedge pin_cs) begin bcnt = 0; m_do = 1'b1; end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        summary();
      end
    end
  end

  task automatic run(input logic [15:0] v, input logic [15:0] p, input logic [7:0] cdelta,
                     input logic [7:0] ports, input logic [3:0] rem, input logic [7:0] pwr,
                     input logic [7:0] lv, input logic [7:0] lp, input logic [7:0] ls);
    logic [7:0] csum;
    bit csok, acc;
    int n, nexp;
    int exp_addr[8] = '{0, 1, 2, 3, 4, 8, 32, 56};
    csum = v[7:0] + v[15:8] + p[7:0] + p[15:8] + 8'd1 + cdelta;
    csok = (cdelta == 0);
    acc  = csok && ports >= 1 && ports <= 4 && pwr <= 8'hFA;
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    mem[0] = v; mem[1] = p; mem[2] = {8'hFF, csum}; mem[3] = {4'h0, rem, ports};
    mem[4] = {8'hFF, pwr}; mem[8] = {8'hFF, lv}; mem[32] = {8'hFF, lp}; mem[56] = {8'hFF, ls};
    rd_q.delete(); proto_err = 0; led_green = 0; led_amber = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(pins_owned === 1 && done === 0 && cfg_valid === 0 && pin_g2_oe === 0, "R12",
        "reset state", {pins_owned, done, cfg_valid, pin_g2_oe}, 4'b1000);
    rst_n = 1;
    n = 0;
    while (done !== 1'b1 && n < 20000) begin
      @(negedge clk); n++;
      if (done !== 1'b1)
        chk(pins_owned === 1 && pin_g2_oe === 0 && cfg_valid === 0, "R10",
            "pins held while loading", {pins_owned, pin_g2_oe, cfg_valid}, 3'b100);
    end
    chk(done === 1 && pins_owned === 0, "R12", "done with release", {done, pins_owned}, 2'b10);
    chk(proto_err == 0, "R2", "read command framing errors", proto_err, 0);
    nexp = csok ? 8 : 3;
    chk(rd_q.size() == nexp, "R4", "number of word reads", rd_q.size(), nexp);
    for (int i = 0; i < rd_q.size() && i < 8; i++)
      chk(rd_q[i] == exp_addr[i], "R8", "read address order", rd_q[i], exp_addr[i]);
    chk(cfg_valid === acc, acc ? "R3" : "R9", "cfg_valid", cfg_valid, acc);
    chk(vid === (acc ? v : DVID), "R1", "vid", vid, acc ? v : DVID);
    chk(pid === (acc ? p : DPID), "R1", "pid", pid, acc ? p : DPID);
    chk(port_cnt === (acc ? ports[2:0] : 3'd4), "R5", "port_cnt", port_cnt, acc ? ports[2:0] : 3'd4);
    chk(nonremovable === (acc ? rem : 4'h0), "R7", "nonremovable", nonremovable, acc ? rem : 4'h0);
    chk(max_power === (acc ? pwr : 8'h32), "R6", "max_power", max_power, acc ? pwr : 8'h32);
    chk({len_vendor, len_product, len_serial} === (acc ? {lv, lp, ls} : 24'h0), "R8",
        "string lengths", {len_vendor, len_product, len_serial}, acc ? {lv, lp, ls} : 24'h0);
    for (int k = 0; k < 4; k++) begin
      led_green = 2'(k); led_amber = 2'(3 - k);
      @(negedge clk);
      chk(done === 0, "R12", "done single cycle", done, 0);
      chk(pin_sk === led_green[0] && pin_g2_out === led_green[1] && pin_g2_oe === 1, "R10",
          "green pins to LED", {pin_sk, pin_g2_out, pin_g2_oe}, {led_green[0], led_green[1], 1'b1});
      chk(pin_cs === (!acc && led_amber[0]) && pin_di === (!acc && led_amber[1]), "R11",
          "amber pins", {pin_cs, pin_di}, {!acc && led_amber[0], !acc && led_amber[1]});
    end
  endtask

  initial begin
    run(16'h05E3, 16'h0608, 8'd0, 8'd3, 4'b1010, 8'h64, 8'h10, 8'h20, 8'h0C); // accepted
    run(16'h05E3, 16'h0608, 8'd1, 8'd3, 4'b1010, 8'h64, 8'h10, 8'h20, 8'h0C); // R4 bad checksum
    run(16'h1111, 16'h2222, 8'd0, 8'd0, 4'b0001, 8'h10, 8'h01, 8'h02, 8'h03); // R5 ports 0
    run(16'h1111, 16'h2222, 8'd0, 8'd5, 4'b0001, 8'h10, 8'h01, 8'h02, 8'h03); // R5 ports 5
    run(16'h7777, 16'h8888, 8'd0, 8'd1, 4'b0110, 8'hFA, 8'h05, 8'h06, 8'h07); // R6 edge ok
    run(16'h7777, 16'h8888, 8'd0, 8'd4, 4'b0110, 8'hFB, 8'h05, 8'h06, 8'h07); // R6 over
    run(16'hFFFF, 16'hFFFF, 8'd0, 8'd4, 4'b1111, 8'h00, 8'h2F, 8'h2E, 8'h10); // R3 wrap
    summary();
  end
endmodule